// File: doc/BRIEF.md
# Manchester Bit Receiver with Drift Tracking

This block recovers bits from a Manchester-coded serial line. A sample-enable input paces it at sixteen ticks per nominal bit. After a two-flop synchroniser, the line is watched for transitions. An internal bit timer predicts where the next mid-bit transition should fall. The first transition seen while the block is unlocked defines the grid. From then on, every mid-bit transition is classified by its offset from the predicted position. The offset can fall in a small jitter band, an early band, a late band, a slip position that counts as an error, or the region near the bit boundary, which is ignored.

When drift tracking is enabled, an early or late mid-bit transition makes the current bit one tick shorter or one tick longer. The grid therefore follows a transmitter whose clock runs a little fast or slow. Each decoded bit leaves the block as a value with a one-cycle valid strobe. A loss of alignment produces a one-cycle error pulse, and the block then waits for a fresh transition to realign. While the decoder enable is low, the block is held idle.

Top module: `manch_rx`

## Requirements
- R1: After reset, bit_valid and sync_err are both 0.
- R2: A rising mid-bit transition decodes as 1 and a falling one decodes as 0. Each decoded bit gives a one-cycle bit_valid pulse. The first transition accepted while unlocked only sets the grid, counts as offset 0, and produces no bit.
- R3: A mid-bit transition at offset -1, 0 or +1 ticks from the predicted position is decoded with no error and no change to the bit length.
- R4: With comp_en high, a mid-bit transition 2, 3 or 4 ticks early is decoded, and the current bit lasts 15 ticks instead of 16. This moves the next prediction one tick earlier.
- R5: With comp_en high, a mid-bit transition 2 or 3 ticks late is decoded, and the current bit lasts 17 ticks. This moves the next prediction one tick later.
- R6: With comp_en low, every bit lasts 16 ticks. Early or late transitions are still decoded but move nothing, so a transmitter running at 15 or 17 ticks per bit eventually causes sync_err.
- R7: A transition exactly 5 ticks early or 4 ticks late raises sync_err for one cycle. No bit is produced for it, the block unlocks, and the next transition realigns the grid.
- R8: If no mid-bit transition has arrived by 4 ticks after the predicted position, sync_err pulses once and the block unlocks.
- R9: Transitions 6 or more ticks before, or 5 or more ticks after, the predicted position are bit-boundary transitions. They are ignored, so runs of equal bits decode without error.
- R10: While dec_en is low, the block produces no bit_valid and no sync_err. Line activity during that time is ignored, and the block is unlocked when dec_en rises.
- R11: Bit timing advances only in cycles where samp_en is high. Outputs change only in the cycle after such a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample tick, 16 per nominal bit |
| rxd | input | 1 | Asynchronous serial line, idles high |
| comp_en | input | 1 | Enables drift tracking |
| dec_en | input | 1 | Enables decoding; low clears lock and outputs |
| bit_out | output | 1 | Last decoded bit value |
| bit_valid | output | 1 | One-cycle strobe for bit_out |
| sync_err | output | 1 | One-cycle loss-of-alignment pulse |

## Verification
A single displaced mid-bit transition is swept across every offset from five ticks early to four ticks late, with drift tracking both on and off. This separates the jitter, early, late and slip bands at each of their edges. Pairs of displaced transitions expose the exact size of a correction: a second displacement is accepted or rejected depending on whether the first one moved the grid by exactly one tick. Transmitters running at 15 and 17 ticks per bit, sending data with runs of equal bits, show that tracking keeps lock where a fixed period loses it, and that boundary transitions are ignored. A silent line and a toggling line with the decoder disabled cover the missing-transition and idle cases.

// File: rtl/manch_pkg.sv
package manch_pkg;

    localparam int NOM_BIT_TICKS = 16;
    localparam int JITTER_TOL    = 1;
    localparam int EARLY_LIMIT   = 4;
    localparam int LATE_LIMIT    = 3;

    typedef enum logic [2:0] {
        ZN_BOUNDARY,
        ZN_CENTER,
        ZN_EARLY,
        ZN_LATE,
        ZN_SLIP
    } zone_e;

    typedef enum logic [1:0] {
        ADJ_NONE,
        ADJ_SHORT,
        ADJ_LONG
    } adj_e;

    typedef struct packed {
        logic seen;
        logic level;
    } line_ev_t;

    function automatic zone_e zone_of(input int off);
        if (off >= -JITTER_TOL && off <= JITTER_TOL)
            return ZN_CENTER;
        else if (off >= -EARLY_LIMIT && off < -JITTER_TOL)
            return ZN_EARLY;
        else if (off > JITTER_TOL && off <= LATE_LIMIT)
            return ZN_LATE;
        else if (off == -(EARLY_LIMIT + 1) || off == LATE_LIMIT + 1)
            return ZN_SLIP;
        else
            return ZN_BOUNDARY;
    endfunction

endpackage

// File: rtl/manch_line_sync.sv
module manch_line_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                rxd,
    output manch_pkg::line_ev_t ev
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rxd};
            if (tick)
                prev_q <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        ev.seen  = tick && (chain_q[STAGES-1] != prev_q);
        ev.level = chain_q[STAGES-1];
    end
endmodule

// File: rtl/manch_bit_timer.sv
module manch_bit_timer #(
    parameter int NOM_LEN = 16,
    parameter int PW      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             restart,
    input  manch_pkg::adj_e  adj,
    output logic [PW-1:0]    phase,
    output logic             at_end
);
    import manch_pkg::*;

    localparam int MID = NOM_LEN / 2;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] len_q;

    assign phase  = phase_q;
    assign at_end = (phase_q == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
            len_q   <= PW'(NOM_LEN);
        end else if (tick) begin
            if (restart) begin
                phase_q <= PW'(MID + 1);
                len_q   <= PW'(NOM_LEN);
            end else if (at_end) begin
                phase_q <= '0;
                len_q   <= PW'(NOM_LEN);
            end else begin
                phase_q <= phase_q + 1'b1;
                case (adj)
                    ADJ_SHORT: len_q <= PW'(NOM_LEN - 1);
                    ADJ_LONG:  len_q <= PW'(NOM_LEN + 1);
                    default:   len_q <= len_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/manch_edge_window.sv
module manch_edge_window #(
    parameter int NOM_LEN = 16,
    parameter int PW      = 5
) (
    input  logic [PW-1:0]    phase,
    output manch_pkg::zone_e zone,
    output logic             deadline
);
    import manch_pkg::*;

    localparam int MID      = NOM_LEN / 2;
    localparam int LAST_POS = MID + LATE_LIMIT + 1;

    always_comb begin
        zone     = zone_of(int'(phase) - MID);
        deadline = (int'(phase) == LAST_POS);
    end
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
    parameter int NOM_LEN     = manch_pkg::NOM_BIT_TICKS,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic rxd,
    input  logic comp_en,
    input  logic dec_en,
    output logic bit_out,
    output logic bit_valid,
    output logic sync_err
);
    import manch_pkg::*;

    localparam int PW = $clog2(NOM_LEN + 2);

    line_ev_t      ev;
    zone_e         zone;
    adj_e          adj;
    logic [PW-1:0] phase;
    logic          at_end;
    logic          deadline;
    logic          locked;
    logic          mid_seen;
    logic          in_mid;
    logic          acquire;
    logic          good;
    logic          err;

    manch_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .tick (samp_en),
        .rxd  (rxd),
        .ev   (ev)
    );

    manch_edge_window #(.NOM_LEN(NOM_LEN), .PW(PW)) u_window (
        .phase    (phase),
        .zone     (zone),
        .deadline (deadline)
    );

    manch_bit_timer #(.NOM_LEN(NOM_LEN), .PW(PW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (!dec_en),
        .tick    (samp_en),
        .restart (acquire),
        .adj     (adj),
        .phase   (phase),
        .at_end  (at_end)
    );

    always_comb begin
        in_mid  = (zone == ZN_CENTER) || (zone == ZN_EARLY) || (zone == ZN_LATE);
        acquire = dec_en && !locked && ev.seen;
        good    = locked && ev.seen && in_mid && !mid_seen;
        err     = locked && samp_en &&
                  ((ev.seen && ((zone == ZN_SLIP) || (in_mid && mid_seen))) ||
                   (deadline && !mid_seen));
        adj     = ADJ_NONE;
        if (good && comp_en) begin
            if (zone == ZN_EARLY)
                adj = ADJ_SHORT;
            else if (zone == ZN_LATE)
                adj = ADJ_LONG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !dec_en) begin
            locked    <= 1'b0;
            mid_seen  <= 1'b0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
            sync_err  <= 1'b0;
        end else begin
            bit_valid <= good;
            sync_err  <= err;
            if (good)
                bit_out <= ev.level;
            if (acquire)
                locked <= 1'b1;
            else if (err)
                locked <= 1'b0;
            if (acquire || good)
                mid_seen <= 1'b1;
            else if (samp_en && at_end)
                mid_seen <= 1'b0;
        end
    end
endmodule

// File: rtl/manch_rx_chk.sv
module manch_rx_chk #(
    parameter int NOM_LEN = 16,
    parameter int PW      = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          samp_en,
    input logic          dec_en,
    input logic          bit_valid,
    input logic          sync_err,
    input logic          locked,
    input logic [PW-1:0] phase
);
    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

    p_valid_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && sync_err));

    p_err_unlocks_r7: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> !locked);

    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(dec_en) |-> (!bit_valid && !sync_err));

    p_out_after_tick_r11: assert property (@(posedge clk) disable iff (rst)
        (bit_valid || sync_err) |-> $past(samp_en));

    p_phase_cap_r5: assert property (@(posedge clk) disable iff (rst)
        phase <= PW'(NOM_LEN));
endmodule

bind manch_rx manch_rx_chk #(.NOM_LEN(NOM_LEN), .PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .samp_en   (samp_en),
    .dec_en    (dec_en),
    .bit_valid (bit_valid),
    .sync_err  (sync_err),
    .locked    (locked),
    .phase     (phase)
);

// File: tb/manch_rx_bench.sv
`timescale 1ns/1ps
module manch_rx_bench;
    localparam logic [23:0] PAT = 24'hB38E59;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic samp_en = 1'b0;
    logic rxd = 1'b1;
    logic comp_en = 1'b0;
    logic dec_en = 1'b0;
    logic bit_out;
    logic bit_valid;
    logic sync_err;

    int   n_chk = 0;
    int   n_fail = 0;
    int   n_got = 0;
    int   n_serr = 0;
    logic got [0:63];

    always #2.5 clk = ~clk;
    always @(posedge clk) samp_en <= ~samp_en;

    manch_rx u_manch_rx (
        .clk       (clk),
        .rst       (rst),
        .samp_en   (samp_en),
        .rxd       (rxd),
        .comp_en   (comp_en),
        .dec_en    (dec_en),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .sync_err  (sync_err)
    );

    always @(negedge clk) begin
        if (bit_valid) begin
            if (n_got < 64) got[n_got] = bit_out;
            n_got = n_got + 1;
        end
        if (sync_err) n_serr = n_serr + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        int k = 0;
        rxd = lvl;
        while (k < n) begin
            @(negedge clk);
            if (samp_en) k++;
        end
    endtask

    task automatic send_bit(input logic b, input int first, input int second);
        hold(~b, first);
        hold(b, second);
    endtask

    task automatic begin_run(input logic comp);
        @(negedge clk);
        dec_en  = 1'b0;
        comp_en = comp;
        hold(1'b1, 4);
        dec_en = 1'b1;
        hold(1'b1, 4);
        n_got  = 0;
        n_serr = 0;
    endtask

    task automatic end_run();
        dec_en = 1'b0;
        hold(1'b1, 4);
    endtask

    // Alternating stream 0,1,0,1,0,1,0 (first bit aligns the grid);
    // bits 2 and 3 have their mid transition displaced by oa and ob ticks.
    task automatic run_pair(input logic comp, input int oa, input int ob, input string req);
        int   offs [7];
        logic expb [7];
        int   n_exp = 0;
        int   exp_err = 0;
        int   shift = 0;
        bit   lk = 0;
        for (int i = 0; i < 7; i++) offs[i] = 0;
        offs[2] = oa;
        offs[3] = ob;
        for (int i = 0; i < 7; i++) begin
            int d = offs[i] - shift;
            if (!lk) begin
                lk = 1;
                shift = offs[i];
            end else if (d >= -4 && d <= 3) begin
                expb[n_exp] = logic'(i % 2);
                n_exp++;
                if (comp && d <= -2) shift--;
                else if (comp && d >= 2) shift++;
            end else begin
                exp_err++;
                lk = 0;
            end
        end
        begin_run(comp);
        for (int i = 0; i < 7; i++)
            send_bit(logic'(i % 2), 8 + offs[i], 8 - offs[i]);
        end_run();
        check(n_serr == exp_err, {req, " error count"}, n_serr, exp_err);
        check(n_got == n_exp, {req, " bit count"}, n_got, n_exp);
        for (int j = 0; j < 7; j++)
            if (j < n_exp && j < n_got)
                check(got[j] == expb[j], {req, " bit value"}, int'(got[j]), int'(expb[j]));
    endtask

    // Sync bit then PAT, transmitter halves h1/h2 ticks long.
    task automatic run_drift(input logic comp, input int h1, input int h2, input string req);
        begin_run(comp);
        send_bit(1'b0, h1, h2);
        for (int i = 0; i < 24; i++)
            send_bit(PAT[23 - i], h1, h2);
        end_run();
        if (comp || (h1 + h2 == 16)) begin
            check(n_serr == 0, {req, " no error"}, n_serr, 0);
            check(n_got == 24, {req, " bit count"}, n_got, 24);
            for (int j = 0; j < 24; j++)
                if (j < n_got)
                    check(got[j] == PAT[23 - j], {req, " bit value"}, int'(got[j]), int'(PAT[23 - j]));
        end else begin
            check(n_serr > 0, {req, " fixed period loses lock"}, n_serr, 1);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(bit_valid == 1'b0, "R1 bit_valid", int'(bit_valid), 0);
        check(sync_err == 1'b0, "R1 sync_err", int'(sync_err), 0);

        // R2 / R9: nominal period, runs of equal bits, fixed period
        run_drift(1'b0, 8, 8, "R2_R9 nominal");

        // R3 R4 R5 R7: single displacement sweep, tracking off and on
        for (int c = 0; c < 2; c++) begin
            for (int d = -5; d <= 4; d++) begin
                string tag;
                if (d >= -1 && d <= 1) tag = "R3 jitter";
                else if (d >= -4 && d <= -2) tag = "R4 early";
                else if (d >= 2 && d <= 3) tag = "R5 late";
                else tag = "R7 slip";
                run_pair(logic'(c), 0, d, tag);
            end
        end

        // R4: one-tick shortening, then a late displacement
        run_pair(1'b1, -2, 3, "R4 shorten then +3");
        run_pair(1'b1, -2, 2, "R4 shorten exactly one");
        run_pair(1'b0, -2, 3, "R6 no shorten");
        // R5: one-tick lengthening, then an early displacement
        run_pair(1'b1, 2, -4, "R5 lengthen then -4");
        run_pair(1'b1, 2, -3, "R5 lengthen exactly one");
        run_pair(1'b0, 2, -4, "R6 no lengthen");

        // R4 R5 R9: drifting transmitter with tracking
        run_drift(1'b1, 7, 8, "R4 fast transmitter");
        run_drift(1'b1, 8, 9, "R5 slow transmitter");
        // R6: drifting transmitter without tracking
        run_drift(1'b0, 7, 8, "R6 fast fixed");
        run_drift(1'b0, 8, 9, "R6 slow fixed");

        // R8: mid transition never arrives
        begin_run(1'b1);
        send_bit(1'b0, 8, 8);
        send_bit(1'b1, 8, 8);
        hold(1'b1, 24);
        check(n_serr == 1, "R8 missing transition error", n_serr, 1);
        check(n_got == 1, "R8 bit count", n_got, 1);
        if (n_got > 0) check(got[0] == 1'b1, "R8 bit value", int'(got[0]), 1);
        end_run();

        // R10: decoder disabled while the line toggles
        begin_run(1'b1);
        dec_en = 1'b0;
        for (int i = 0; i < 6; i++) send_bit(logic'(i % 2), 8, 8);
        check(n_got == 0, "R10 no bits when disabled", n_got, 0);
        check(n_serr == 0, "R10 no error when disabled", n_serr, 0);
        // R11: after re-enabling, the first transition only aligns
        dec_en = 1'b1;
        n_got = 0;
        send_bit(1'b0, 8, 8);
        send_bit(1'b1, 8, 8);
        end_run();
        check(n_got == 1, "R11 realign then decode", n_got, 1);

        finish_run();
    end
endmodule